// File: doc/BRIEF.md
# Multi-Chip Divided-Clock Phase Aligner

This block divides the system clock by four with a two-bit phase counter and keeps that counter in step across several identical chips that share the same system clock. One chip is set up as the timing source and sends a one-cycle pulse on `sync_out` once per divided period. The other chips take that pulse on `sync_in` and compare its arrival against their own counter. Each time the two disagree, the receiving chip holds its counter for one system-clock cycle. That nudges its divided clock a quarter period (90°) later. A few held cycles bring it into line with the source.

The pulse may take several system-clock cycles to travel between chips. A two-bit delay setting tells a receiver how many whole cycles of extra delay to expect. Phase can also be nudged by hand, with no source chip involved. In the software variant, an update strobe gives one held cycle. In the hardware variant, each rising edge on `sync_in` gives one held cycle. A sticky alarm records that a receiver found itself out of step. A read strobe clears it, and a mask forces it low.

Top module: `sync_clk_aligner`

## Requirements
- R1: After reset the phase count is 0, `div_clk` is high, `sync_alarm` is low. Each cycle without a hold, the count steps 0,1,2,3,0. `div_clk` is high for counts 0 and 1 and low for 2 and 3. A held cycle keeps the count unchanged for exactly one cycle.
- R2: Source role (`master_en`=1, both manual modes off): `sync_out` is high for exactly one system-clock cycle, in the cycle where the count is 0. It is therefore high once per divided period. In every other role `sync_out` stays low.
- R3: When `master_en` and `slave_en` are both set, the block acts as a source. `sync_in` edges cause no held cycles and never set the alarm.
- R4: `sync_in` passes through two flip-flops, and a rising edge is found on the synchronized value. In receiver role (`slave_en`=1, `master_en`=0, manual modes off), an edge arriving while the count differs from (2 + `delay_ofs`) mod 4 holds the count for one cycle. An edge arriving at the matching count leaves the counter running.
- R5: A receiver fed a source pulse whose travel delay is d whole cycles, with `delay_ofs`=d, matches the source count within three source pulses (at most three held cycles). After that, its count equals the source count.
- R6: If `delay_ofs` exceeds the true delay d by k, the receiver settles with its count k ahead of the source (mod 4). That is a residual error of k × 90° of the divided clock.
- R7: `sync_alarm` goes high on the cycle after a receiver holds on a mismatch. It stays high, even when the counts later agree, until a cycle with `status_rd`=1 and no new mismatch. A mismatch in the same cycle as the read wins.
- R8: While `status_mask`=1, `sync_alarm` is low from the next cycle on, and mismatches do not set it.
- R9: Manual software mode (`manual_sw`=1): each cycle with `io_update`=1 holds the count for exactly one cycle. `sync_in` edges and the receiver comparison have no effect.
- R10: Manual hardware mode (`manual_hw`=1, `manual_sw`=0): each synchronized rising edge of `sync_in` holds the count for one cycle. The receiver comparison is off and the alarm is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Alignment pulse from the source chip, or manual nudge edges |
| master_en | input | 1 | Source role enable |
| slave_en | input | 1 | Receiver (automatic) role enable |
| manual_sw | input | 1 | Manual software nudge mode |
| manual_hw | input | 1 | Manual hardware nudge mode |
| delay_ofs | input | 2 | Expected extra travel delay of the source pulse, in whole cycles |
| status_mask | input | 1 | Forces the alarm low |
| io_update | input | 1 | Update strobe; one held cycle in manual software mode |
| status_rd | input | 1 | Alarm read strobe; clears the alarm |
| sync_out | output | 1 | One-cycle alignment pulse in source role |
| div_clk | output | 1 | Divided clock, system clock / 4 |
| sync_alarm | output | 1 | Sticky out-of-step alarm |

## Verification
On every cycle, the assertions check the following:
- the width of the source pulse;
- that the count steps by one except on a held cycle;
- that a software strobe or a hardware edge freezes the count;
- that the alarm stays set until read, and drops under the mask.

Only the bench scenarios can show the behaviour that depends on a second chip. One case is convergence onto an emulated source within three pulses for each delay setting. Another is the fixed quarter-period residual left by a wrong delay setting. A third is that the source role overrides the receiver role, which the bench shows through the absence of any phase shift.

// File: rtl/sync_clk_aligner.sv
module sync_clk_aligner #(
  parameter int PHASES   = 4,
  parameter int SYNC_LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       master_en,
  input  logic       slave_en,
  input  logic       manual_sw,
  input  logic       manual_hw,
  input  logic [1:0] delay_ofs,
  input  logic       status_mask,
  input  logic       io_update,
  input  logic       status_rd,
  output logic       sync_out,
  output logic       div_clk,
  output logic       sync_alarm
);
  localparam int CW = $clog2(PHASES);

  logic [CW-1:0] cnt, exp_cnt;
  logic [2:0]    sq;
  logic          alarm_q;
  logic          manual, src_act, rcv_act, rise, auto_stall, stall;

  assign manual     = manual_sw | manual_hw;
  assign src_act    = master_en & ~manual;
  assign rcv_act    = slave_en & ~master_en & ~manual;
  assign rise       = sq[1] & ~sq[2];
  assign exp_cnt    = CW'(SYNC_LAT) + CW'(delay_ofs);
  assign auto_stall = rcv_act & rise & (cnt != exp_cnt);
  assign stall      = (manual_sw & io_update)
                    | (manual_hw & ~manual_sw & rise)
                    | auto_stall;

  assign div_clk    = (cnt < CW'(PHASES / 2));
  assign sync_out   = src_act & (cnt == '0);
  assign sync_alarm = alarm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sq      <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (!stall) cnt <= cnt + 1'b1;
      sq <= {sq[1:0], sync_in};
      if (status_mask)     alarm_q <= 1'b0;
      else if (auto_stall) alarm_q <= 1'b1;
      else if (status_rd)  alarm_q <= 1'b0;
    end
  end

  // R2: source pulse lasts one system-clock cycle
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out);

  // R1: counter advances by one unless held
  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> cnt == CW'($past(cnt) + 1'b1));

  // R9: software strobe freezes the count
  a_r9_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (manual_sw && io_update) |=> $stable(cnt));

  // R10: hardware edge freezes the count
  a_r10_hw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (manual_hw && !manual_sw && rise) |=> $stable(cnt));

  // R7: alarm is sticky until read
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_alarm && !status_rd && !status_mask) |=> sync_alarm);

  // R8: mask clears the alarm
  a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
    status_mask |=> !sync_alarm);

  // R3: source role never sets the alarm
  a_r3_src_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && !sync_alarm) |=> !sync_alarm);
endmodule

// File: tb/sync_clk_aligner_test.sv
module sync_clk_aligner_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_in = 1'b0, master_en = 1'b0, slave_en = 1'b0;
  logic manual_sw = 1'b0, manual_hw = 1'b0, status_mask = 1'b0;
  logic io_update = 1'b0, status_rd = 1'b0;
  logic [1:0] delay_ofs = 2'd0;
  logic sync_out, div_clk, sync_alarm;

  sync_clk_aligner uut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .master_en(master_en),
    .slave_en(slave_en), .manual_sw(manual_sw), .manual_hw(manual_hw),
    .delay_ofs(delay_ofs), .status_mask(status_mask), .io_update(io_update),
    .status_rd(status_rd), .sync_out(sync_out), .div_clk(div_clk),
    .sync_alarm(sync_alarm)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int tests = 0, fails = 0;
  string ctx = "R1";
  logic [1:0] m_cnt = 2'd0;
  logic [2:0] m_sq = 3'd0;
  logic m_alarm = 1'b0;
  logic use_vm = 1'b0;
  logic [1:0] vm = 2'd0;
  logic [3:0] vline = 4'd0;
  int vdel = 0;
  logic phase_chk = 1'b0;
  logic [1:0] phase_k = 2'd0;

  function automatic logic exp_div(input logic [1:0] c);
    return c < 2'd2;
  endfunction

  function automatic logic model_stall(input logic [1:0] c, input logic [2:0] q);
    logic rise, man, rcv;
    rise = q[1] & ~q[2];
    man  = manual_sw | manual_hw;
    rcv  = slave_en & ~master_en & ~man;
    return (manual_sw & io_update) | (manual_hw & ~manual_sw & rise)
         | (rcv & rise & (c != 2'(2 + delay_ofs)));
  endfunction

  function automatic logic model_mismatch(input logic [1:0] c, input logic [2:0] q);
    return slave_en & ~master_en & ~manual_sw & ~manual_hw & q[1] & ~q[2]
         & (c != 2'(2 + delay_ofs));
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic st, mm;
    logic [1:0] nc;
    if (use_vm) begin
      vline = {vline[2:0], (vm == 2'd0)};
      sync_in = vline[vdel];
    end
    #1;
    chk(ctx, "div_clk", div_clk, exp_div(m_cnt));
    chk(ctx, "sync_out", sync_out, master_en & ~manual_sw & ~manual_hw & (m_cnt == 2'd0));
    chk(ctx, "sync_alarm", sync_alarm, m_alarm);
    if (phase_chk) chk(ctx, "phase vs source", div_clk, exp_div(2'(vm + phase_k)));
    st = model_stall(m_cnt, m_sq);
    mm = model_mismatch(m_cnt, m_sq);
    nc = st ? m_cnt : 2'(m_cnt + 1);
    @(posedge clk);
    m_cnt = nc;
    m_alarm = status_mask ? 1'b0 : mm ? 1'b1 : status_rd ? 1'b0 : m_alarm;
    m_sq = {m_sq[1:0], sync_in};
    vm = 2'(vm + 1);
    @(negedge clk);
  endtask

  task automatic idle();
    master_en = 0; slave_en = 0; manual_sw = 0; manual_hw = 0;
    status_mask = 0; io_update = 0; status_rd = 0; sync_in = 0;
    use_vm = 0; phase_chk = 0;
  endtask

  task automatic run_source(input int d, input int ofs, input int start, input int k);
    idle();
    status_rd = 1; tick(); status_rd = 0;
    vm = 2'(start); vline = 0; vdel = d; delay_ofs = 2'(ofs);
    slave_en = 1; use_vm = 1;
    repeat (20) tick();
    phase_k = 2'(k); phase_chk = 1;
    repeat (12) tick();
    phase_chk = 0;
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
          fails++; tests++;
          $display("FAIL watchdog expired");
          $display("  [TB] %0d tests run, %0d failed", tests, fails);
          $finish;
        end
      end
    join_none
    void'($urandom(32'd4242));
    @(negedge clk);
    #1;
    ctx = "R1";
    chk("R1", "reset div_clk", div_clk, 1'b1);
    chk("R1", "reset alarm", sync_alarm, 1'b0);
    chk("R1", "reset sync_out", sync_out, 1'b0);
    @(negedge clk); rst_n = 1;
    repeat (8) tick();

    ctx = "R2"; master_en = 1;
    repeat (12) tick();

    ctx = "R3"; slave_en = 1;
    for (int i = 0; i < 16; i++) begin sync_in = i[1]; tick(); end
    chk("R3", "no alarm as source", sync_alarm, 1'b0);

    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++) begin
        ctx = "R5"; run_source(d, d, s, 0);
      end
    ctx = "R4";
    run_source(0, 0, 1, 0);
    chk("R4", "alarm after mismatch", sync_alarm, 1'b1);

    ctx = "R6";
    run_source(0, 1, 2, 1);
    run_source(1, 3, 0, 2);
    run_source(0, 3, 1, 3);

    ctx = "R7";
    run_source(0, 0, 3, 0);
    chk("R7", "alarm stays after regain", sync_alarm, 1'b1);
    use_vm = 0; slave_en = 0; status_rd = 1; tick(); status_rd = 0; tick();
    chk("R7", "alarm cleared by read", sync_alarm, 1'b0);

    ctx = "R8";
    run_source(0, 0, 2, 0);
    status_mask = 1; tick(); tick();
    chk("R8", "mask forces low", sync_alarm, 1'b0);
    status_mask = 0;

    ctx = "R9"; idle(); manual_sw = 1; slave_en = 1;
    for (int i = 0; i < 20; i++) begin
      io_update = (i % 5 == 2); sync_in = i[0]; tick();
    end
    io_update = 0;

    ctx = "R10"; idle(); manual_hw = 1; slave_en = 1;
    for (int i = 0; i < 24; i++) begin sync_in = (i % 6) < 2; tick(); end
    chk("R10", "no alarm in manual", sync_alarm, 1'b0);

    ctx = "R4";
    idle();
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      master_en   = (r < 15);
      slave_en    = $urandom_range(0, 3) != 0;
      manual_sw   = (r >= 90);
      manual_hw   = (r >= 80 && r < 90);
      delay_ofs   = 2'($urandom_range(0, 3));
      status_mask = $urandom_range(0, 19) == 0;
      status_rd   = $urandom_range(0, 9) == 0;
      io_update   = $urandom_range(0, 3) == 0;
      sync_in     = $urandom_range(0, 2) == 0;
      tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule